// File: doc/BRIEF.md
# Collision Jam and Backoff Controller

This controller handles collisions for a half-duplex transmitter. The transmit logic tells it when an attempt starts and whether the preamble is still on the line. When a collision is reported during an attempt, the controller waits for any preamble in progress to finish. It then sends a fixed 32-bit jam pattern on a byte-wide output. When the jam ends, it computes a random backoff delay and waits that long.

The delay is a whole number of slot times. A free-running pseudo-random register supplies the value. That value is masked to a width set by the number of attempts made on the current frame, and the width stops growing after ten attempts. One slot time is a programmable number of bit-time ticks. After the wait, the controller pulses a retry request to the transmit logic. If the frame has already used its full budget of attempts, the controller skips the backoff and reports that it is giving up. A successful transmission clears the attempt history, so the next frame starts again from its first attempt.

Top module: `col_backoff_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `jam_valid`, `jam_data`, `backoff_busy`, `retry_req` and `give_up` are all zero.
- R2: A collision sampled during an attempt while `preamble_active` is low raises `jam_valid` in the next cycle. `jam_valid` stays high for exactly JAM_BYTES (4) consecutive cycles, and each of those bytes on `jam_data` is 0xAA.
- R3: A collision sampled while `preamble_active` is high produces no jam byte while `preamble_active` stays high. The jam starts in the cycle after `preamble_active` is first sampled low.
- R4: Unless the controller gives up, `backoff_busy` rises in the cycle right after the last jam byte. With `bit_tick` high every cycle, it stays high for r*SLOT_BITS+1 cycles, where r is a whole number of slots.
- R5: For attempt n of a frame (n counts from 1), the slot count r satisfies 0 <= r < 2^min(n, BACKOFF_LIMIT), with BACKOFF_LIMIT = 10.
- R6: `retry_req` is a single-cycle pulse. It occurs in the cycle right after `backoff_busy` falls.
- R7: On a collision in attempt number MAX_ATTEMPTS (16), no backoff follows the jam. Instead `give_up` pulses for one cycle right after the last jam byte, and the attempt count returns to zero, so the next attempt is attempt 1 again.
- R8: `tx_success` during an attempt ends it with no jam, no backoff and no retry. It also clears the attempt count, so the next attempt is attempt 1.
- R9: `collision` has no effect while no attempt is active. No jam, backoff, retry or give-up follows it.
- R10: At most one of `jam_valid`, `backoff_busy`, `retry_req` and `give_up` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One pulse per bit time; paces the slot timer |
| tx_start | input | 1 | Starts a transmit attempt (accepted when idle) |
| preamble_active | input | 1 | High while the transmitter sends preamble |
| collision | input | 1 | Collision detected on the medium |
| tx_success | input | 1 | Current attempt completed without collision |
| jam_data | output | 8 | Jam byte (0xAA while valid, else 0) |
| jam_valid | output | 1 | Jam byte valid |
| backoff_busy | output | 1 | Backoff delay in progress |
| retry_req | output | 1 | One-cycle request to retransmit |
| give_up | output | 1 | One-cycle excessive-collision abort |

## Verification
Some properties are checked by assertions on every cycle. These are the value of each jam byte and the length of every jam burst. They also cover jam never starting while the preamble was sampled active, backoff or give-up always following the last jam byte, retry and give-up being single-cycle pulses, and the four outputs never overlapping. Other behaviour depends on the attempt number, so only the bench scenarios can show it. This includes the range bound on the slot count, which widens with each attempt and then stops at ten. It also includes the give-up on the sixteenth attempt, the reset of the attempt count after give-up or success, and the fact that a backoff lasts exactly a whole number of slots.

// File: rtl/cb_pkg.sv
package cb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_WAIT_PRE,
    ST_JAM,
    ST_BACKOFF,
    ST_RETRY,
    ST_ABORT
  } cb_state_e;

  localparam logic [7:0] JAM_BYTE = 8'hAA;

  // Galois feedback masks for a few maximal-length widths
  function automatic logic [63:0] lfsr_taps(input int w);
    case (w)
      12:      lfsr_taps = 64'h0000_0000_0000_0E08;
      16:      lfsr_taps = 64'h0000_0000_0000_B400;
      20:      lfsr_taps = 64'h0000_0000_0009_0000;
      24:      lfsr_taps = 64'h0000_0000_00E1_0000;
      default: lfsr_taps = 64'h0000_0000_A300_0000;
    endcase
  endfunction
endpackage

// File: rtl/cb_lfsr.sv
module cb_lfsr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] value
);
  localparam logic [63:0] TAPS64 = cb_pkg::lfsr_taps(W);
  localparam logic [W-1:0] TAPS  = TAPS64[W-1:0];

  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= {{(W-1){1'b0}}, 1'b1};
    else     q <= {1'b0, q[W-1:1]} ^ (q[0] ? TAPS : '0);
  end

  assign value = q;
endmodule

// File: rtl/cb_attempt_ctr.sv
module cb_attempt_ctr #(
  parameter int MAX_ATTEMPTS  = 16,
  parameter int BACKOFF_LIMIT = 10,
  parameter int RW            = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          clr,
  output logic          at_last,
  output logic [RW-1:0] range_mask
);
  localparam int AW = $clog2(MAX_ATTEMPTS + 1);

  logic [AW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clr)                               count_q <= '0;
    else if (inc && count_q != AW'(MAX_ATTEMPTS)) count_q <= count_q + 1'b1;
  end

  assign at_last = (count_q >= AW'(MAX_ATTEMPTS));

  // bit i is set when i < min(count, limit): mask = 2^k - 1
  for (genvar i = 0; i < RW; i++) begin : g_mask
    if (i < BACKOFF_LIMIT) begin : g_live
      assign range_mask[i] = (32'(count_q) > i);
    end else begin : g_dead
      assign range_mask[i] = 1'b0;
    end
  end
endmodule

// File: rtl/cb_slot_timer.sv
module cb_slot_timer #(
  parameter int SLOT_BITS = 512,
  parameter int CW        = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_slots,
  input  logic          bit_tick,
  output logic          zero
);
  localparam int TW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

  logic [CW-1:0] slots_q;
  logic [TW-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slots_q <= '0;
      tick_q  <= '0;
    end else if (load) begin
      slots_q <= load_slots;
      tick_q  <= '0;
    end else if (slots_q != '0 && bit_tick) begin
      if (tick_q == TW'(SLOT_BITS - 1)) begin
        tick_q  <= '0;
        slots_q <= slots_q - 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign zero = (slots_q == '0);
endmodule

// File: rtl/col_backoff_ctrl.sv
module col_backoff_ctrl #(
  parameter int SLOT_BITS     = 512,
  parameter int MAX_ATTEMPTS  = 16,
  parameter int BACKOFF_LIMIT = 10,
  parameter int LFSR_W        = 16,
  parameter int JAM_BYTES     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_tick,
  input  logic       tx_start,
  input  logic       preamble_active,
  input  logic       collision,
  input  logic       tx_success,
  output logic [7:0] jam_data,
  output logic       jam_valid,
  output logic       backoff_busy,
  output logic       retry_req,
  output logic       give_up
);
  import cb_pkg::*;

  localparam int JW = $clog2(JAM_BYTES + 1);

  cb_state_e state_q, state_d;
  logic [JW-1:0] jam_cnt_q, jam_cnt_d;
  logic att_inc, att_clr, att_last;
  logic slot_load, slot_zero;
  logic [LFSR_W-1:0] rnd, mask;

  cb_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk(clk), .rst(rst), .value(rnd)
  );

  cb_attempt_ctr #(
    .MAX_ATTEMPTS(MAX_ATTEMPTS), .BACKOFF_LIMIT(BACKOFF_LIMIT), .RW(LFSR_W)
  ) u_att (
    .clk(clk), .rst(rst), .inc(att_inc), .clr(att_clr),
    .at_last(att_last), .range_mask(mask)
  );

  cb_slot_timer #(.SLOT_BITS(SLOT_BITS), .CW(LFSR_W)) u_slot (
    .clk(clk), .rst(rst), .load(slot_load), .load_slots(rnd & mask),
    .bit_tick(bit_tick), .zero(slot_zero)
  );

  always_comb begin
    state_d   = state_q;
    jam_cnt_d = '0;
    att_inc   = 1'b0;
    att_clr   = 1'b0;
    slot_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (tx_start) begin
          att_inc = 1'b1;
          state_d = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (tx_success) begin
          att_clr = 1'b1;
          state_d = ST_IDLE;
        end else if (collision) begin
          state_d = preamble_active ? ST_WAIT_PRE : ST_JAM;
        end
      end
      ST_WAIT_PRE: begin
        if (!preamble_active) state_d = ST_JAM;
      end
      ST_JAM: begin
        if (jam_cnt_q == JW'(JAM_BYTES - 1)) begin
          if (att_last) begin
            att_clr = 1'b1;
            state_d = ST_ABORT;
          end else begin
            slot_load = 1'b1;
            state_d   = ST_BACKOFF;
          end
        end else begin
          jam_cnt_d = jam_cnt_q + 1'b1;
        end
      end
      ST_BACKOFF: begin
        if (slot_zero) state_d = ST_RETRY;
      end
      ST_RETRY: state_d = ST_IDLE;
      ST_ABORT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      jam_cnt_q    <= '0;
      jam_valid    <= 1'b0;
      jam_data     <= '0;
      backoff_busy <= 1'b0;
      retry_req    <= 1'b0;
      give_up      <= 1'b0;
    end else begin
      state_q      <= state_d;
      jam_cnt_q    <= jam_cnt_d;
      jam_valid    <= (state_d == ST_JAM);
      jam_data     <= (state_d == ST_JAM) ? JAM_BYTE : 8'h00;
      backoff_busy <= (state_d == ST_BACKOFF);
      retry_req    <= (state_d == ST_RETRY);
      give_up      <= (state_d == ST_ABORT);
    end
  end
endmodule

// File: rtl/col_backoff_ctrl_chk.sv
module col_backoff_ctrl_chk #(
  parameter int JAM_BYTES = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       preamble_active,
  input logic [7:0] jam_data,
  input logic       jam_valid,
  input logic       backoff_busy,
  input logic       retry_req,
  input logic       give_up
);
  logic [7:0] jam_run;

  always_ff @(posedge clk) begin
    if (rst)            jam_run <= '0;
    else if (jam_valid) jam_run <= jam_run + 1'b1;
    else                jam_run <= '0;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!jam_valid && jam_data == 8'h00 && !backoff_busy && !retry_req && !give_up));

  p_jam_byte_r2: assert property (@(posedge clk) disable iff (rst)
    jam_valid |-> jam_data == 8'hAA);

  p_jam_not_long_r2: assert property (@(posedge clk) disable iff (rst)
    jam_valid |-> jam_run < 8'(JAM_BYTES));

  p_jam_full_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(jam_valid) |-> jam_run == 8'(JAM_BYTES));

  p_jam_after_pre_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(jam_valid) |-> !$past(preamble_active));

  p_backoff_follows_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(jam_valid) |-> (backoff_busy || give_up));

  p_retry_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    retry_req |=> !retry_req);

  p_retry_after_busy_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(retry_req) |-> $past(backoff_busy));

  p_giveup_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    give_up |=> !give_up);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({jam_valid, backoff_busy, retry_req, give_up}));
endmodule

bind col_backoff_ctrl col_backoff_ctrl_chk #(.JAM_BYTES(JAM_BYTES)) u_chk (
  .clk(clk), .rst(rst), .preamble_active(preamble_active),
  .jam_data(jam_data), .jam_valid(jam_valid), .backoff_busy(backoff_busy),
  .retry_req(retry_req), .give_up(give_up)
);

// File: tb/col_backoff_ctrl_tb.sv
module col_backoff_ctrl_tb;
  localparam int SLOT = 4;
  localparam int MAXA = 16;
  localparam int LIM  = 10;
  localparam int EV_RETRY = 256;
  localparam int EV_GIVE  = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b1;
  logic tx_start = 1'b0, preamble_active = 1'b0, collision = 1'b0, tx_success = 1'b0;
  logic [7:0] jam_data;
  logic jam_valid, backoff_busy, retry_req, give_up;

  int checks = 0, fails = 0, cyc = 0;
  int exp_q[$];
  int exp_k = 1;
  int busy_len = 0;
  int bench_n = 0;
  bit done = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  col_backoff_ctrl #(.SLOT_BITS(SLOT), .MAX_ATTEMPTS(MAXA), .BACKOFF_LIMIT(LIM)) u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_start(tx_start),
    .preamble_active(preamble_active), .collision(collision), .tx_success(tx_success),
    .jam_data(jam_data), .jam_valid(jam_valid), .backoff_busy(backoff_busy),
    .retry_req(retry_req), .give_up(give_up)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic pop_cmp(input int got, input string req);
    int e;
    if (exp_q.size() == 0) begin
      chk(1'b0, {req, " unexpected event"}, got, -1);
    end else begin
      e = exp_q.pop_front();
      chk(got == e, req, got, e);
    end
  endtask

  // monitor: compares produced events with the scoreboard queue
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (jam_valid) pop_cmp(int'(jam_data), "R2 jam byte");
      if (backoff_busy) busy_len++;
      if (retry_req) begin
        chk(((busy_len - 1) % SLOT) == 0, "R4 whole slots", busy_len - 1, 0);
        chk(((busy_len - 1) / SLOT) < (1 << exp_k), "R5 slot range",
            (busy_len - 1) / SLOT, (1 << exp_k) - 1);
        pop_cmp(EV_RETRY, "R6 retry event");
        busy_len = 0;
        done = 1'b1;
      end
      if (give_up) begin
        chk(busy_len == 0, "R7 no backoff before give-up", busy_len, 0);
        pop_cmp(EV_GIVE, "R7 give-up event");
        busy_len = 0;
        done = 1'b1;
      end
    end
  end

  task automatic summary();
    finished = 1'b1;
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      chk(1'b0, "watchdog", cyc, 190000);
      summary();
    end
  end

  // one attempt: pre_len > 0 means the collision lands inside the preamble
  task automatic do_attempt(input int pre_len, input bit succeed);
    int k;
    @(negedge clk);
    tx_start = 1'b1;
    preamble_active = (pre_len > 0);
    @(negedge clk);
    tx_start = 1'b0;
    bench_n++;
    if (succeed) begin
      tx_success = 1'b1;
      preamble_active = 1'b0;
      @(negedge clk);
      tx_success = 1'b0;
      collision = 1'b1;               // after success, no attempt is active
      repeat (3) @(negedge clk);
      collision = 1'b0;
      chk(!jam_valid && !backoff_busy && !retry_req, "R8 success ends attempt",
          int'({jam_valid, backoff_busy, retry_req}), 0);
      bench_n = 0;
      return;
    end
    collision = 1'b1;
    k = (bench_n < LIM) ? bench_n : LIM;
    exp_k = k;
    repeat (4) exp_q.push_back(8'hAA);
    exp_q.push_back((bench_n == MAXA) ? EV_GIVE : EV_RETRY);
    done = 1'b0;
    @(negedge clk);
    collision = 1'b0;
    if (pre_len > 0) begin
      for (int i = 0; i < pre_len; i++) begin
        chk(!jam_valid, "R3 no jam during preamble", int'(jam_valid), 0);
        @(negedge clk);
      end
      preamble_active = 1'b0;
      @(negedge clk);
      chk(jam_valid, "R3 jam after preamble", int'(jam_valid), 1);
    end else begin
      chk(jam_valid, "R2 jam next cycle", int'(jam_valid), 1);
    end
    while (!done) @(negedge clk);
    if (bench_n == MAXA) bench_n = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!jam_valid && jam_data == 8'h00 && !backoff_busy && !retry_req && !give_up,
        "R1 reset outputs", int'({jam_valid, backoff_busy, retry_req, give_up}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!jam_valid && !backoff_busy, "R1 idle after reset",
        int'({jam_valid, backoff_busy}), 0);

    // R9: collision with no attempt active
    collision = 1'b1;
    repeat (5) @(negedge clk);
    collision = 1'b0;
    @(negedge clk);
    chk(!jam_valid && !backoff_busy && !retry_req && !give_up, "R9 idle collision ignored",
        int'({jam_valid, backoff_busy, retry_req, give_up}), 0);

    // a full frame: 16 collided attempts, mixed preamble timing, ends in give-up (R7)
    for (int a = 0; a < MAXA; a++) do_attempt((a % 3 == 1) ? (a % 5) + 1 : 0, 1'b0);

    // R7: count restarted, next attempt is n=1
    do_attempt(0, 1'b0);
    do_attempt(2, 1'b0);
    do_attempt(0, 1'b1);

    // R8: several collisions then success; next frame restarts at n=1
    for (int a = 0; a < 6; a++) do_attempt(0, 1'b0);
    do_attempt(0, 1'b1);
    for (int a = 0; a < 3; a++) do_attempt(1, 1'b0);
    do_attempt(0, 1'b1);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule